// File: doc/BRIEF.md
# Serial Register Port with Burst Motion Readout

This block is the sensor-side end of a four-wire serial register port. The host lowers chip select and sends an address byte. The top bit of that byte picks a write or a read. A data byte then follows, either into the port or out of it. Several commands may follow one another while chip select stays low. The port reads the sensor's live measurement bytes and a small bank of writable configuration registers. Two one-cycle pulses tell the motion accumulators that a displacement value has been delivered, so that the sensor logic can clear it.

A read of one reserved address starts a burst. On the last address bit the port freezes all seven measurement bytes into one 56-bit snapshot. It then clocks the bytes out back to back, with no further address and no gap between bytes. After the last burst bit the port stops responding to the clock. It stays in that state until chip select has been high for a set number of system clocks, and this holds even for a new burst command. Raising chip select part way through a burst also ends it, under the same exit rule.

All serial inputs are taken to be synchronous to the system clock already. The clock idles high. The port samples the data input on each serial clock rising edge. It advances its output on that same edge, so each output bit is valid while the serial clock is low, before the edge that consumes it.

Top module: `rp_burst_port`

## Requirements
- R1: The address byte arrives MSB first, one bit per serial clock rising edge. Bit 7 is 1 for a write and 0 for a read, and bits 6:0 give the register. Read data leaves MSB first on miso, with each bit valid while sclk is low and advancing on each rising edge.
- R2: A read of addresses 0x02..0x08 returns, in that order, motion status, delta X, delta Y, surface quality, shutter high, shutter low and peak pixel. Addresses 0x10..0x13 return configuration registers 0..3, and any other address returns 0x00.
- R3: A write to 0x10+i updates cfg_o[8*i+7:8*i] once its eighth data bit has been received. A write to any other address changes no readable value.
- R4: A read of address 0x50 streams 56 bits back to back, in the same byte order as in R2, each byte MSB first.
- R5: The burst bytes are the input values present on the clock that takes the last address bit. Later changes to the inputs do not alter them.
- R6: dx_clr_o pulses for one clock when a read of 0x03 or a burst takes its address. dy_clr_o does the same for 0x04 or a burst.
- R7: After the 56th burst bit, with chip select still low, the port ignores the serial clock. miso stays 0, writes have no effect, and a new burst command is not decoded.
- R8: Outside burst and lock-out, a chip select high drops any partial byte. The next byte after chip select falls is then taken as an address.
- R9: To leave a burst or the lock-out, chip select must be high for EXIT_CYC consecutive clocks. A shorter high pulse leaves the port locked. A burst cut short after its delta X byte obeys the same rule.
- R10: After reset, miso_o is 0, every configuration register is 0x00 and both clear pulses are low.
- R11: Outside burst mode, several commands may run back to back within one chip select low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle high |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| motion_i | input | 8 | Motion status byte |
| dx_i | input | 8 | Accumulated delta X |
| dy_i | input | 8 | Accumulated delta Y |
| squal_i | input | 8 | Surface quality |
| shut_hi_i | input | 8 | Shutter time, upper byte |
| shut_lo_i | input | 8 | Shutter time, lower byte |
| maxpix_i | input | 8 | Peak pixel value |
| cfg_o | output | 8*N_CFG | Configuration registers, register i in bits 8*i+7:8*i |
| dx_clr_o | output | 1 | One-clock pulse when delta X has been read |
| dy_clr_o | output | 1 | One-clock pulse when delta Y has been read |

## Verification
A bad bit counter or a wrong sequencer state shows up on miso within the clock that follows the next serial clock edge. The stream then shifts by a bit or stops early, so the bench's clock-by-clock model of the output catches it on that clock. A lock-out or exit count that is off shows only when the host next tries a command. A read that should return a configuration value then gives zeros, or a read that should be blocked returns data. The clear pulses are compared on every clock, so a missing or extra pulse is seen in the same cycle that the address completes.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int BYTE_W = 8;
    localparam int N_SNAP = 7;
    localparam int SNAP_W = BYTE_W * N_SNAP;

    localparam logic [6:0] A_SENS_BASE = 7'h02;
    localparam logic [6:0] A_DX        = 7'h03;
    localparam logic [6:0] A_DY        = 7'h04;
    localparam logic [6:0] A_CFG_BASE  = 7'h10;
    localparam logic [6:0] A_BURST     = 7'h50;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_BURST,
        ST_LOCK,
        ST_EXIT
    } port_st_e;

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
    } cmd_t;

    // States that only a long enough chip select high can leave
    function automatic logic sticky(port_st_e s);
        return (s == ST_BURST) || (s == ST_LOCK) || (s == ST_EXIT);
    endfunction

endpackage

// File: rtl/rp_edge.sv
module rp_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic rise_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
endmodule

// File: rtl/rp_regmap.sv
module rp_regmap
    import rp_pkg::*;
#(
    parameter int N_CFG = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en_i,
    input  logic [6:0]              wr_addr_i,
    input  byte_t                   wr_data_i,
    input  logic [6:0]              rd_addr_i,
    input  logic [SNAP_W-1:0]       sens_i,
    output byte_t                   rd_data_o,
    output logic [SNAP_W-1:0]       snap_o,
    output logic [N_CFG*BYTE_W-1:0] cfg_o
);
    byte_t cfg_q [N_CFG];

    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[g] <= '0;
            else if (wr_en_i && wr_addr_i == 7'(int'(A_CFG_BASE) + g))
                cfg_q[g] <= wr_data_i;
        end
        assign cfg_o[BYTE_W*g +: BYTE_W] = cfg_q[g];

        // R3
        cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(cfg_q[g]) |-> $past(wr_en_i));
    end

    // Snapshot order: sensor byte 0 leaves first, so it sits at the MSB end
    for (genvar k = 0; k < N_SNAP; k++) begin : g_snap
        assign snap_o[SNAP_W-1-BYTE_W*k -: BYTE_W] = sens_i[BYTE_W*k +: BYTE_W];
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_SNAP; i++)
            if (rd_addr_i == 7'(int'(A_SENS_BASE) + i))
                rd_data_o = sens_i[BYTE_W*i +: BYTE_W];
        for (int j = 0; j < N_CFG; j++)
            if (rd_addr_i == 7'(int'(A_CFG_BASE) + j))
                rd_data_o = cfg_q[j];
    end
endmodule

// File: rtl/rp_ctrl.sv
module rp_ctrl
    import rp_pkg::*;
#(
    parameter int EXIT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic              rise_i,
    input  byte_t             rd_data_i,
    input  logic [SNAP_W-1:0] snap_i,
    output logic [6:0]        rd_addr_o,
    output logic              wr_en_o,
    output logic [6:0]        wr_addr_o,
    output byte_t             wr_data_o,
    output logic              dx_clr_o,
    output logic              dy_clr_o,
    output logic              miso_o
);
    localparam int EXW = $clog2(EXIT_CYC + 1);
    localparam int BCW = $clog2(SNAP_W);

    port_st_e          st_q;
    logic [BCW-1:0]    bit_q;
    logic [6:0]        in_sh;
    logic [SNAP_W-1:0] out_sh;
    logic [EXW-1:0]    ex_q, ex_nxt;
    logic [6:0]        wa_q;
    logic              wr_en_q, dxc_q, dyc_q;
    byte_t             wr_data_q;
    byte_t             byte_w;
    cmd_t              cmd;
    logic              last8, lastb;

    assign byte_w    = {in_sh, mosi_i};
    assign cmd       = cmd_t'(byte_w);
    assign rd_addr_o = cmd.addr;
    assign last8     = (bit_q == BCW'(BYTE_W - 1));
    assign lastb     = (bit_q == BCW'(SNAP_W - 1));
    assign ex_nxt    = (st_q == ST_EXIT) ? ex_q + EXW'(1) : EXW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_ADDR;
            bit_q     <= '0;
            in_sh     <= '0;
            out_sh    <= '0;
            ex_q      <= '0;
            wa_q      <= '0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
            dxc_q     <= 1'b0;
            dyc_q     <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            dxc_q   <= 1'b0;
            dyc_q   <= 1'b0;
            if (cs_n_i) begin
                bit_q <= '0;
                if (sticky(st_q)) begin
                    if (ex_nxt >= EXW'(EXIT_CYC)) begin
                        st_q <= ST_ADDR;
                        ex_q <= '0;
                    end else begin
                        st_q <= ST_EXIT;
                        ex_q <= ex_nxt;
                    end
                end else begin
                    st_q <= ST_ADDR;
                end
            end else if (st_q == ST_EXIT) begin
                st_q <= ST_LOCK;
                ex_q <= '0;
            end else if (rise_i) begin
                unique case (st_q)
                    ST_ADDR: begin
                        in_sh <= byte_w[6:0];
                        if (last8) begin
                            bit_q <= '0;
                            if (cmd.wr) begin
                                wa_q <= cmd.addr;
                                st_q <= ST_WDATA;
                            end else if (cmd.addr == A_BURST) begin
                                out_sh <= snap_i;
                                st_q   <= ST_BURST;
                                dxc_q  <= 1'b1;
                                dyc_q  <= 1'b1;
                            end else begin
                                out_sh <= {rd_data_i, {(SNAP_W-BYTE_W){1'b0}}};
                                st_q   <= ST_RDATA;
                                dxc_q  <= (cmd.addr == A_DX);
                                dyc_q  <= (cmd.addr == A_DY);
                            end
                        end else begin
                            bit_q <= bit_q + BCW'(1);
                        end
                    end
                    ST_WDATA: begin
                        in_sh <= byte_w[6:0];
                        if (last8) begin
                            wr_en_q   <= 1'b1;
                            wr_data_q <= byte_w;
                            st_q      <= ST_ADDR;
                            bit_q     <= '0;
                        end else begin
                            bit_q <= bit_q + BCW'(1);
                        end
                    end
                    ST_RDATA: begin
                        out_sh <= out_sh << 1;
                        if (last8) begin
                            st_q  <= ST_ADDR;
                            bit_q <= '0;
                        end else begin
                            bit_q <= bit_q + BCW'(1);
                        end
                    end
                    ST_BURST: begin
                        out_sh <= out_sh << 1;
                        if (lastb) begin
                            st_q  <= ST_LOCK;
                            bit_q <= '0;
                        end else begin
                            bit_q <= bit_q + BCW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso_o    = (st_q == ST_RDATA || st_q == ST_BURST) ? out_sh[SNAP_W-1] : 1'b0;
    assign wr_en_o   = wr_en_q;
    assign wr_addr_o = wa_q;
    assign wr_data_o = wr_data_q;
    assign dx_clr_o  = dxc_q;
    assign dy_clr_o  = dyc_q;

    // R6
    clr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (dx_clr_o || dy_clr_o) |-> (st_q == ST_RDATA || st_q == ST_BURST));
    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BURST) |-> (bit_q <= BCW'(SNAP_W - 1)));
    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && !cs_n_i) |=> (st_q == ST_LOCK));
    // R9
    exit_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EXIT && !cs_n_i) |=> (st_q == ST_LOCK));
    // R8
    cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && !sticky(st_q)) |=> (st_q == ST_ADDR && bit_q == '0));
    // R3
    wr_src_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> ($past(st_q) == ST_WDATA));
endmodule

// File: rtl/rp_burst_port.sv
module rp_burst_port
    import rp_pkg::*;
#(
    parameter int N_CFG    = 4,
    parameter int EXIT_CYC = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs_n_i,
    input  logic                    sclk_i,
    input  logic                    mosi_i,
    output logic                    miso_o,
    input  logic [7:0]              motion_i,
    input  logic [7:0]              dx_i,
    input  logic [7:0]              dy_i,
    input  logic [7:0]              squal_i,
    input  logic [7:0]              shut_hi_i,
    input  logic [7:0]              shut_lo_i,
    input  logic [7:0]              maxpix_i,
    output logic [N_CFG*BYTE_W-1:0] cfg_o,
    output logic                    dx_clr_o,
    output logic                    dy_clr_o
);
    logic              rise;
    logic [6:0]        rd_addr, wr_addr;
    logic              wr_en;
    byte_t             wr_data, rd_data;
    logic [SNAP_W-1:0] sens, snap;

    assign sens = {maxpix_i, shut_lo_i, shut_hi_i, squal_i, dy_i, dx_i, motion_i};

    rp_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .rise_o (rise)
    );

    rp_regmap #(.N_CFG(N_CFG)) u_map (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .sens_i    (sens),
        .rd_data_o (rd_data),
        .snap_o    (snap),
        .cfg_o     (cfg_o)
    );

    rp_ctrl #(.EXIT_CYC(EXIT_CYC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_n_i    (cs_n_i),
        .mosi_i    (mosi_i),
        .rise_i    (rise),
        .rd_data_i (rd_data),
        .snap_i    (snap),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .dx_clr_o  (dx_clr_o),
        .dy_clr_o  (dy_clr_o),
        .miso_o    (miso_o)
    );
endmodule

// File: tb/rp_burst_port_tb_top.sv
module rp_burst_port_tb_top;
    localparam int EXIT = 16;
    localparam int NC   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
    logic miso, dx_clr, dy_clr;
    logic [NC*8-1:0] cfg;
    logic [7:0] sens [7];

    int n_chk = 0, n_fail = 0, cyc = 0, dxcnt = 0, dycnt = 0;

    always #4 clk = ~clk;

    rp_burst_port #(.N_CFG(NC), .EXIT_CYC(EXIT)) dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
        .miso_o(miso), .motion_i(sens[0]), .dx_i(sens[1]), .dy_i(sens[2]),
        .squal_i(sens[3]), .shut_hi_i(sens[4]), .shut_lo_i(sens[5]),
        .maxpix_i(sens[6]), .cfg_o(cfg), .dx_clr_o(dx_clr), .dy_clr_o(dy_clr)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_mode, m_bits, m_ex;
    logic [6:0] m_wa;
    logic [7:0] m_sh;
    logic m_prev, m_rise, e_dx, e_dy;
    logic m_q[$];
    logic [7:0] m_cfg [NC];

    function automatic logic [7:0] model_val(logic [6:0] a);
        if (a >= 7'h02 && a <= 7'h08) return sens[a - 7'h02];
        if (a >= 7'h10 && a < 7'h10 + NC) return m_cfg[a - 7'h10];
        return 8'h00;
    endfunction

    task automatic push_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_q.push_back(v[i]);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_bits = 0; m_ex = 0; m_wa = '0; m_sh = '0;
            m_prev = 1'b1; e_dx = 1'b0; e_dy = 1'b0; m_q.delete();
            for (int i = 0; i < NC; i++) m_cfg[i] = 8'h00;
        end else begin
            m_rise = sclk && !m_prev;
            m_prev = sclk;
            e_dx = 1'b0; e_dy = 1'b0;
            if (cs_n) begin
                m_bits = 0;
                if (m_mode >= 3) begin
                    m_ex = (m_mode == 5) ? m_ex + 1 : 1;
                    if (m_ex >= EXIT) begin m_mode = 0; m_ex = 0; end
                    else m_mode = 5;
                end else m_mode = 0;
            end else if (m_mode == 5) begin
                m_mode = 4; m_ex = 0;
            end else if (m_rise) begin
                case (m_mode)
                    0: begin
                        m_sh = {m_sh[6:0], mosi}; m_bits++;
                        if (m_bits == 8) begin
                            m_bits = 0;
                            if (m_sh[7]) begin m_wa = m_sh[6:0]; m_mode = 1; end
                            else if (m_sh[6:0] == 7'h50) begin
                                m_q.delete();
                                for (int k = 0; k < 7; k++) push_byte(sens[k]);
                                m_mode = 3; e_dx = 1'b1; e_dy = 1'b1;
                            end else begin
                                m_q.delete();
                                push_byte(model_val(m_sh[6:0]));
                                m_mode = 2;
                                e_dx = (m_sh[6:0] == 7'h03);
                                e_dy = (m_sh[6:0] == 7'h04);
                            end
                        end
                    end
                    1: begin
                        m_sh = {m_sh[6:0], mosi}; m_bits++;
                        if (m_bits == 8) begin
                            if (m_wa >= 7'h10 && m_wa < 7'h10 + NC) m_cfg[m_wa - 7'h10] = m_sh;
                            m_mode = 0; m_bits = 0;
                        end
                    end
                    2: begin
                        void'(m_q.pop_front()); m_bits++;
                        if (m_bits == 8) begin m_mode = 0; m_bits = 0; end
                    end
                    3: begin
                        void'(m_q.pop_front()); m_bits++;
                        if (m_bits == 56) begin m_mode = 4; m_bits = 0; end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Clock-by-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic exp_miso;
            exp_miso = ((m_mode == 2 || m_mode == 3) && m_q.size() > 0) ? m_q[0] : 1'b0;
            if (m_mode == 3)      chk("R4", "burst miso", miso, exp_miso);
            else if (m_mode == 2) chk("R1", "read miso", miso, exp_miso);
            else if (m_mode >= 4) chk("R7", "locked miso", miso, exp_miso);
            else                  chk("R8", "idle miso", miso, exp_miso);
            chk("R6", "dx_clr", dx_clr, e_dx);
            chk("R6", "dy_clr", dy_clr, e_dy);
            if (dx_clr) dxcnt++;
            if (dy_clr) dycnt++;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- host tasks ----------------
    task automatic bit_xfer(input logic b, output logic o);
        @(negedge clk); sclk = 1'b0; mosi = b;
        repeat (3) @(negedge clk);
        o = miso; sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic xfer_byte(input logic [7:0] v, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_xfer(v[i], b);
            o[i] = b;
        end
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_high(int n);
        @(negedge clk); cs_n = 1'b1; sclk = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] dummy;
        xfer_byte({1'b0, a}, dummy);
        xfer_byte(8'h00, d);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] v);
        logic [7:0] dummy;
        xfer_byte({1'b1, a}, dummy);
        xfer_byte(v, dummy);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] d, dummy;
        logic [7:0] snap_exp [7];
        int dx0, dy0;
        sens[0] = 8'h81; sens[1] = 8'h1F; sens[2] = 8'hE2; sens[3] = 8'h5A;
        sens[4] = 8'h03; sens[5] = 8'hC4; sens[6] = 8'h96;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "miso after reset", miso, 1'b0);
        chk("R10", "cfg after reset", cfg, '0);
        chk("R10", "clr pulses after reset", {dx_clr, dy_clr}, 2'b00);

        // R2 plain reads, mapped and unmapped
        cs_low();
        read_reg(7'h02, d); chk("R2", "read motion", d, 8'h81);
        read_reg(7'h05, d); chk("R2", "read squal", d, 8'h5A);
        read_reg(7'h08, d); chk("R2", "read peak pixel", d, 8'h96);
        read_reg(7'h30, d); chk("R2", "read unmapped", d, 8'h00);
        cs_high(4);

        // R3 writes
        cs_low();
        write_reg(7'h10, 8'h3C);
        write_reg(7'h12, 8'hA5);
        read_reg(7'h12, d); chk("R3", "readback cfg2", d, 8'hA5);
        chk("R3", "cfg_o", cfg, 32'h00A5_003C);
        write_reg(7'h02, 8'h00);
        read_reg(7'h02, d); chk("R3", "write to sensor ignored", d, 8'h81);
        write_reg(7'h20, 8'hFF);
        chk("R3", "unmapped write ignored", cfg, 32'h00A5_003C);
        // R11 back to back in the same chip select window
        read_reg(7'h06, d); chk("R11", "chained read shutter high", d, 8'h03);
        read_reg(7'h10, d); chk("R11", "chained read cfg0", d, 8'h3C);
        cs_high(4);

        // R6 single reads of delta registers
        dx0 = dxcnt; dy0 = dycnt;
        cs_low();
        read_reg(7'h03, d); chk("R6", "read dx value", d, 8'h1F);
        read_reg(7'h04, d); chk("R6", "read dy value", d, 8'hE2);
        cs_high(4);
        chk("R6", "dx pulse count", dxcnt - dx0, 1);
        chk("R6", "dy pulse count", dycnt - dy0, 1);

        // R8 abort mid-byte
        cs_low();
        for (int i = 7; i >= 3; i--) begin logic b; bit_xfer(i[0], b); end
        cs_high(2);
        cs_low();
        read_reg(7'h07, d); chk("R8", "read after abort", d, 8'hC4);
        cs_high(4);

        // R4 R5 R6 full burst with inputs changing after the address
        for (int k = 0; k < 7; k++) snap_exp[k] = sens[k];
        dx0 = dxcnt; dy0 = dycnt;
        cs_low();
        xfer_byte(8'h50, dummy);
        for (int k = 0; k < 7; k++) sens[k] = ~sens[k];
        for (int k = 0; k < 7; k++) begin
            xfer_byte(8'h00, d);
            chk("R5", "burst byte from snapshot", d, snap_exp[k]);
        end
        chk("R4", "burst dx pulse", dxcnt - dx0, 1);
        chk("R4", "burst dy pulse", dycnt - dy0, 1);

        // R7 locked: new burst and writes ignored
        xfer_byte(8'h50, dummy);
        xfer_byte(8'h00, d); chk("R7", "second burst blocked", d, 8'h00);
        write_reg(7'h10, 8'h77);
        chk("R7", "write ignored when locked", cfg[7:0], 8'h3C);

        // R9 short exit keeps lock, long exit releases
        cs_high(EXIT / 2);
        cs_low();
        read_reg(7'h10, d); chk("R9", "short exit still locked", d, 8'h00);
        cs_high(EXIT + 2);
        cs_low();
        read_reg(7'h10, d); chk("R9", "long exit unlocked", d, 8'h3C);
        cs_high(4);

        // R9 burst cut after delta X byte
        cs_low();
        xfer_byte(8'h50, dummy);
        xfer_byte(8'h00, d); chk("R4", "short burst motion", d, sens[0]);
        xfer_byte(8'h00, d); chk("R4", "short burst dx", d, sens[1]);
        cs_high(EXIT + 2);
        cs_low();
        read_reg(7'h05, d); chk("R9", "read after cut burst", d, sens[3]);
        cs_high(4);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule